// File: doc/BRIEF.md
# Programmable Input Glitch Filter

The block sits between the synchronized digital input pins of a multi-port input unit and the logic that reads them back or watches them for edges. It suppresses pulses that are shorter than a programmed minimum width. One shared interval value sets that width for the whole block. The interval is counted in strobes of an external time base that runs at one strobe per 200 ns. A byte mask per port selects which of that port's eight lines are filtered.

On an enabled line, the filtered output follows the raw input only after the raw value has differed from the output for the full programmed number of strobes. A line whose mask bit is clear passes the raw value through with one register of delay. Every line passes its raw value through while the interval is zero. Writing a new interval, or changing a line's mask bit, clears the affected qualification counters. In that cycle the outputs keep their values.

The register decode that loads the interval and masks, and the generator of the time-base strobe, are outside this block.

Top module: `input_glitch_filter`

## Requirements
- R1: While reset is asserted, every bit of `filt_out` is 0, and the stored interval and mask copies are 0.
- R2: A line whose `filt_en` bit is 0 copies its `raw_in` bit to `filt_out` at the next clock edge, whether or not `tick` is high.
- R3: While `interval` is 0, every line copies its raw bit to `filt_out` at the next clock edge, whatever its `filt_en` bit.
- R4: With interval N > 0 and `tick` high every cycle, a change on an enabled line appears at `filt_out` at the Nth clock edge after the raw value settles, and not before. The output only ever changes to the current raw value.
- R5: A pulse on an enabled line that returns to the output value before N qualifying strobes never reaches `filt_out`. A new change after it again needs a full N strobes.
- R6: The qualification count of an enabled line advances only on cycles with `tick` high. Cycles without a strobe neither advance the count nor change the output of a filtered line.
- R7: A cycle in which `interval` differs from its value in the previous cycle clears every line's count and holds every output. A full new interval is then needed, even if the old count was one strobe from committing.
- R8: A cycle in which a line's `filt_en` bit changes clears that line's count and holds its output for that edge. From the next edge the line follows its new mode.
- R9: Lines are filtered independently. Each has its own count, so changes on different lines at different times commit at their own times.
- R10: Line numbering is port-major. Bit 8*p+l of `raw_in`, `filt_en` and `filt_out` is line l of port p, and a port's mask byte occupies bits 8*p+7 down to 8*p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe, one cycle high per 200 ns |
| raw_in | input | NUM_PORTS*LINES_PER_PORT | Synchronized raw input lines |
| filt_en | input | NUM_PORTS*LINES_PER_PORT | Per-line filter enable, one mask byte per port |
| interval | input | IVAL_W | Shared minimum stable time in strobes (0 disables filtering) |
| filt_out | output | NUM_PORTS*LINES_PER_PORT | Filtered input lines |

## Verification
Two functions can fall on the same edge: a counter reaching the interval, and a configuration change that restarts it. The bench provokes both orderings. It writes a new interval on exactly the cycle that carries the committing strobe, and it clears a line's mask bit one strobe before that line would commit. It then judges that the output held on that edge, and that a full new interval, or the bypass path, decides the next value. Restarts after a glitch and strobe-gated counting are covered with directed pulse widths one strobe short of and equal to the interval.

// File: rtl/ifilt_pkg.sv
package ifilt_pkg;

  localparam int unsigned IFILT_LINES_PER_PORT = 8;
  localparam int unsigned IFILT_IVAL_W         = 20;

  // What a single line does on the coming clock edge.
  typedef enum logic [2:0] {
    LA_HOLD    = 3'd0,  // mismatch but no strobe: keep count and output
    LA_RESTART = 3'd1,  // configuration touched this line: clear count, keep output
    LA_PASS    = 3'd2,  // unfiltered: copy raw value
    LA_IDLE    = 3'd3,  // raw equals output: nothing to qualify
    LA_COUNT   = 3'd4,  // strobe while mismatched: advance count
    LA_COMMIT  = 3'd5   // count reached interval: take raw value
  } line_act_e;

endpackage

// File: rtl/ifilt_cfg_watch.sv
module ifilt_cfg_watch #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned IVAL_W    = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IVAL_W-1:0]    interval,
  input  logic [NUM_LINES-1:0] filt_en,
  output logic                 iv_zero,
  output logic [NUM_LINES-1:0] line_restart
);

  logic [IVAL_W-1:0]    iv_q;
  logic [IVAL_W-1:0]    iv_d;
  logic [NUM_LINES-1:0] en_q;
  logic [NUM_LINES-1:0] en_d;
  logic                 iv_changed;
  logic                 cfg_en;

  always_comb begin
    iv_d         = interval;
    en_d         = filt_en;
    iv_changed   = (interval != iv_q);
    iv_zero      = (interval == '0);
    line_restart = (filt_en ^ en_q) | {NUM_LINES{iv_changed}};
    cfg_en       = iv_changed || (filt_en != en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q <= '0;
      en_q <= '0;
    end else if (cfg_en) begin
      iv_q <= iv_d;
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/ifilt_line.sv
module ifilt_line
  import ifilt_pkg::*;
#(
  parameter int unsigned IVAL_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              raw,
  input  logic              enable,
  input  logic              iv_zero,
  input  logic              restart,
  input  logic [IVAL_W-1:0] interval,
  output logic              filt
);

  logic [IVAL_W-1:0] cnt_q;
  logic [IVAL_W-1:0] cnt_d;
  logic [IVAL_W:0]   cnt_inc;
  logic              out_q;
  logic              out_d;
  logic              cnt_en;
  logic              out_en;
  line_act_e         act;

  // Decide the action; restart has priority over every other path.
  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{IVAL_W{1'b0}}, 1'b1};
    if (restart)                    act = LA_RESTART;
    else if (!enable || iv_zero)    act = LA_PASS;
    else if (raw == out_q)          act = LA_IDLE;
    else if (!tick)                 act = LA_HOLD;
    else if (cnt_inc >= {1'b0, interval}) act = LA_COMMIT;
    else                            act = LA_COUNT;
  end

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    case (act)
      LA_RESTART: cnt_d = '0;
      LA_PASS: begin
        cnt_d = '0;
        out_d = raw;
      end
      LA_IDLE:    cnt_d = '0;
      LA_COUNT:   cnt_d = cnt_inc[IVAL_W-1:0];
      LA_COMMIT: begin
        cnt_d = '0;
        out_d = raw;
      end
      default: begin
        cnt_d = cnt_q;
        out_d = out_q;
      end
    endcase
    cnt_en = (cnt_d != cnt_q);
    out_en = (out_d != out_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (out_en) out_q <= out_d;
    end
  end

  assign filt = out_q;

endmodule

// File: rtl/ifilt_port.sv
module ifilt_port #(
  parameter int unsigned LINES  = 8,
  parameter int unsigned IVAL_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              iv_zero,
  input  logic [IVAL_W-1:0] interval,
  input  logic [LINES-1:0]  raw,
  input  logic [LINES-1:0]  enable,
  input  logic [LINES-1:0]  restart,
  output logic [LINES-1:0]  filt
);

  for (genvar l = 0; l < LINES; l++) begin : g_line
    ifilt_line #(.IVAL_W(IVAL_W)) i_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .raw      (raw[l]),
      .enable   (enable[l]),
      .iv_zero  (iv_zero),
      .restart  (restart[l]),
      .interval (interval),
      .filt     (filt[l])
    );
  end

endmodule

// File: rtl/input_glitch_filter.sv
module input_glitch_filter #(
  parameter int unsigned NUM_PORTS      = 4,
  parameter int unsigned LINES_PER_PORT = ifilt_pkg::IFILT_LINES_PER_PORT,
  parameter int unsigned IVAL_W         = ifilt_pkg::IFILT_IVAL_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick,
  input  logic [NUM_PORTS*LINES_PER_PORT-1:0] raw_in,
  input  logic [NUM_PORTS*LINES_PER_PORT-1:0] filt_en,
  input  logic [IVAL_W-1:0]                   interval,
  output logic [NUM_PORTS*LINES_PER_PORT-1:0] filt_out
);

  localparam int unsigned NUM_LINES = NUM_PORTS * LINES_PER_PORT;

  logic                 iv_zero;
  logic [NUM_LINES-1:0] line_restart;

  ifilt_cfg_watch #(
    .NUM_LINES (NUM_LINES),
    .IVAL_W    (IVAL_W)
  ) i_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .interval     (interval),
    .filt_en      (filt_en),
    .iv_zero      (iv_zero),
    .line_restart (line_restart)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ifilt_port #(
      .LINES  (LINES_PER_PORT),
      .IVAL_W (IVAL_W)
    ) i_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .iv_zero  (iv_zero),
      .interval (interval),
      .raw      (raw_in[p*LINES_PER_PORT +: LINES_PER_PORT]),
      .enable   (filt_en[p*LINES_PER_PORT +: LINES_PER_PORT]),
      .restart  (line_restart[p*LINES_PER_PORT +: LINES_PER_PORT]),
      .filt     (filt_out[p*LINES_PER_PORT +: LINES_PER_PORT])
    );
  end

endmodule

// File: rtl/ifilt_checker.sv
module ifilt_checker #(
  parameter int unsigned NUM_PORTS      = 4,
  parameter int unsigned LINES_PER_PORT = 8,
  parameter int unsigned IVAL_W         = 20
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                tick,
  input logic [NUM_PORTS*LINES_PER_PORT-1:0] raw_in,
  input logic [NUM_PORTS*LINES_PER_PORT-1:0] filt_en,
  input logic [IVAL_W-1:0]                   interval,
  input logic [NUM_PORTS*LINES_PER_PORT-1:0] filt_out
);

  localparam int unsigned NL = NUM_PORTS * LINES_PER_PORT;

  // Checker-side history of the inputs, one and two edges back.
  logic [NL-1:0]     raw_h;
  logic [NL-1:0]     en_h1;
  logic [NL-1:0]     en_h2;
  logic [IVAL_W-1:0] iv_h1;
  logic [IVAL_W-1:0] iv_h2;
  logic              tick_h;
  logic [NL-1:0]     pass_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_h  <= '0;
      en_h1  <= '0;
      en_h2  <= '0;
      iv_h1  <= '0;
      iv_h2  <= '0;
      tick_h <= 1'b0;
    end else begin
      raw_h  <= raw_in;
      en_h1  <= filt_en;
      en_h2  <= en_h1;
      iv_h1  <= interval;
      iv_h2  <= iv_h1;
      tick_h <= tick;
    end
  end

  always_comb begin
    if (iv_h1 != iv_h2) pass_mask = '0;
    else pass_mask = (~en_h1 | {NL{iv_h1 == '0}}) & ~(en_h1 ^ en_h2);
  end

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> filt_out == '0);

  // Covers the unfiltered-line path (R2) and the zero-interval path (R3).
  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_out ^ raw_h) & pass_mask) == '0);

  p_commit_to_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_out ^ $past(filt_out)) & (filt_out ^ raw_h)) == '0);

  p_tick_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_h && iv_h1 != '0) |-> (((filt_out ^ $past(filt_out)) & en_h1) == '0));

  p_iv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_h1 != iv_h2) |-> (filt_out == $past(filt_out)));

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_h1 ^ en_h2) & (filt_out ^ $past(filt_out))) == '0);

endmodule

bind input_glitch_filter ifilt_checker #(
  .NUM_PORTS      (NUM_PORTS),
  .LINES_PER_PORT (LINES_PER_PORT),
  .IVAL_W         (IVAL_W)
) i_ifilt_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .raw_in   (raw_in),
  .filt_en  (filt_en),
  .interval (interval),
  .filt_out (filt_out)
);

// File: tb/test_input_glitch_filter.sv
`timescale 1ns/1ps
module test_input_glitch_filter;

  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick;
  logic [NL-1:0] raw_in;
  logic [NL-1:0] filt_en;
  logic [19:0]   interval;
  logic [NL-1:0] filt_out;

  int n_checks = 0;
  int n_fails  = 0;
  logic [NL-1:0] cur;

  always #2.5 clk = ~clk;

  input_glitch_filter i_input_glitch_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .raw_in   (raw_in),
    .filt_en  (filt_en),
    .interval (interval),
    .filt_out (filt_out)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NL-1:0] got, input logic [NL-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: filt_out=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic settle();
    tick = 1'b1;
    step(12);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick = 1'b0; raw_in = '1; filt_en = '0; interval = '0;
    step(3);
    check("R1 reset clears output", filt_out, '0);
    rst_n = 1'b1;
    step(1);
    check("R3 zero interval passes after reset", filt_out, '1);
  endtask

  task automatic t_passthru();
    logic [NL-1:0] oldv;
    logic [NL-1:0] newv;
    filt_en = '1; raw_in = 32'hA5A5_3C3C;
    step(2);
    check("R3 zero interval ignores enables", filt_out, 32'hA5A5_3C3C);
    raw_in = 32'h0F0F_F0F0;
    step(1);
    check("R3 pass next edge", filt_out, 32'h0F0F_F0F0);
    oldv = 32'h0F0F_F0F0;
    interval = 20'd5; tick = 1'b0;
    step(2);
    filt_en = 32'hFFFF_00FF;
    step(2);
    newv = 32'h1234_5678;
    raw_in = newv;
    step(1);
    check("R2 R10 port1 unfiltered, others held", filt_out,
          (newv & ~filt_en) | (oldv & filt_en));
    step(5);
    check("R6 no strobe keeps filtered lines", filt_out,
          (newv & ~filt_en) | (oldv & filt_en));
    filt_en = '1;
    step(2);
    settle();
    check("R4 settled after strobes", filt_out, newv);
    cur = newv;
  endtask

  task automatic t_timing();
    interval = 20'd4; tick = 1'b1;
    step(2);
    raw_in = cur ^ 32'h1;
    step(3);
    check("R4 before Nth strobe", filt_out, cur);
    step(1);
    check("R4 at Nth strobe", filt_out, cur ^ 32'h1);
    cur = cur ^ 32'h1;
  endtask

  task automatic t_glitch();
    raw_in = cur ^ 32'h100;
    step(3);
    raw_in = cur;
    step(1);
    check("R5 short pulse removed", filt_out, cur);
    step(8);
    check("R5 short pulse stays removed", filt_out, cur);
    raw_in = cur ^ 32'h100;
    step(3);
    raw_in = cur;
    step(1);
    raw_in = cur ^ 32'h100;
    step(3);
    check("R5 count restarted after glitch", filt_out, cur);
    step(1);
    check("R5 full interval after restart", filt_out, cur ^ 32'h100);
    cur = cur ^ 32'h100;
  endtask

  task automatic t_tick();
    interval = 20'd2; tick = 1'b1;
    step(2);
    tick = 1'b0;
    raw_in = cur ^ 32'h1_0000;
    step(20);
    check("R6 no advance without strobe", filt_out, cur);
    tick = 1'b1; step(1); tick = 1'b0;
    check("R6 one strobe not enough", filt_out, cur);
    step(5);
    check("R6 idle cycles keep count", filt_out, cur);
    tick = 1'b1; step(1); tick = 1'b0;
    check("R6 second strobe commits", filt_out, cur ^ 32'h1_0000);
    cur = cur ^ 32'h1_0000;
    tick = 1'b1;
  endtask

  task automatic t_iv_collide();
    interval = 20'd4; tick = 1'b1;
    step(2);
    raw_in = cur ^ 32'h100_0000;
    step(3);
    interval = 20'd5;
    step(1);
    check("R7 interval write holds on commit edge", filt_out, cur);
    step(4);
    check("R7 new full interval needed", filt_out, cur);
    step(1);
    check("R7 commit after new interval", filt_out, cur ^ 32'h100_0000);
    cur = cur ^ 32'h100_0000;
  endtask

  task automatic t_en_collide();
    raw_in = cur ^ 32'h2;
    step(4);
    filt_en = ~32'h2;
    step(1);
    check("R8 mask change holds output", filt_out, cur);
    step(1);
    check("R8 then follows bypass", filt_out, cur ^ 32'h2);
    cur = cur ^ 32'h2;
    filt_en = '1;
    step(2);
  endtask

  task automatic t_independent();
    interval = 20'd4;
    step(2);
    raw_in = cur ^ 32'h8;
    step(2);
    raw_in = raw_in ^ 32'h10_0000;
    step(2);
    check("R9 line 3 commits alone", filt_out, cur ^ 32'h8);
    step(2);
    check("R9 line 20 commits later", filt_out, cur ^ 32'h10_0008);
    cur = cur ^ 32'h10_0008;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_passthru();
        t_timing();
        t_glitch();
        t_tick();
        t_iv_collide();
        t_en_collide();
        t_independent();
      end
      begin
        #500000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule